// File: doc/BRIEF.md
# Input Power-Good Qualifier

This block turns three raw input-supply comparator flags into a filtered power-good indication. The flags report whether the input is above its undervoltage lockout level, whether it exceeds the battery voltage by the required offset, and whether it exceeds the overvoltage threshold. The power-good indication is asserted only while all three conditions are healthy. Each change of the indication is filtered by a deglitch time chosen from the kind of event that caused it and from whether the charger is enabled. Some of these deglitch times are zero, so the change is applied on the next clock.

The block also produces an overvoltage shutdown signal and an enable for the auxiliary regulator. The shutdown signal is set only after the input has stayed over the threshold for a blanking time. It clears as soon as the input drops back below the threshold. The auxiliary regulator runs whenever the input is out of lockout and not shut down, whatever the charger enable says. All times are counted in pulses of a one-microsecond tick input, so the block runs from any system clock.

Top module: `pwr_good_qual`

## Requirements
- R1: While reset is asserted, `pg_sink` and `ovp_shutdown` are 0. The deglitch logic treats the input as having just left lockout.
- R2: When `in_above_uvlo` is low at a clock edge, `pg_sink` is 0 after that edge, whether or not the charger is enabled.
- R3: Power-good returns 230 ticks after lockout ends. A transition with deglitch N is applied at the clock edge that follows N counted ticks during which the new condition held throughout. With N = 0 it is applied at the first edge that sees the change.
- R4: When overvoltage drops power-good, the delay is 100 ticks while `chg_enabled` is 1 and zero while it is 0.
- R5: When the input leaves overvoltage, power-good returns after 450 ticks while enabled and after 500 ticks while disabled.
- R6: When the input falls to or below battery plus offset, power-good drops after 32000 ticks while enabled and with no delay while disabled.
- R7: When the input rises back above battery plus offset, power-good returns after 500 ticks whatever the enable state.
- R8: `ovp_shutdown` rises at the edge after 115 ticks of continuous overvoltage with the input out of lockout. It falls at the first edge at which `in_above_ovp` is low.
- R9: `aux_reg_en` is 1 exactly when `in_above_uvlo` is 1 and `ovp_shutdown` is 0. `chg_enabled` has no effect on it.
- R10: If a condition reverts before its deglitch time ends, the pending change of `pg_sink` is dropped. The next change times its full deglitch from zero.
- R11: When several conditions change in the same cycle, the deglitch is chosen with lockout first, then overvoltage, then sleep. This holds for both the falling and the rising direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse every microsecond; times all deglitch windows |
| in_above_uvlo | input | 1 | Input supply above the undervoltage lockout level |
| in_above_bat | input | 1 | Input supply above battery voltage plus offset |
| in_above_ovp | input | 1 | Input supply above the overvoltage threshold |
| chg_enabled | input | 1 | Charger enable state |
| pg_sink | output | 1 | 1 = drive the open-drain power-good pin low (power good) |
| ovp_shutdown | output | 1 | Charging and auxiliary regulator forced off by overvoltage |
| aux_reg_en | output | 1 | Auxiliary regulator enable |

## Verification
Two functions can act in the same cycle. The first is the power-good deglitch selection: several comparator flags can move on the same edge, and each would pick a different delay. The second is the overvoltage blanking counter, which runs alongside the power-good drop. The bench drives lockout and overvoltage, and then overvoltage and sleep, together in single steps, in both directions. A result passes only if the delay matches the higher-priority cause: immediate or 230 ticks for lockout, 100 or 450 ticks for overvoltage. During overvoltage steps the shutdown and the regulator enable are scored on their own expected edges, so a shutdown that fires early or stays stuck is reported apart from the power-good timing.

// File: rtl/pwr_good_qual.sv
module pwr_good_qual #(
  parameter int T_UVLO_EXIT     = 230,
  parameter int T_OVP_ENTER_EN  = 100,
  parameter int T_OVP_EXIT_EN   = 450,
  parameter int T_OVP_EXIT_DIS  = 500,
  parameter int T_SLEEP_ENTER_EN = 32000,
  parameter int T_SLEEP_EXIT    = 500,
  parameter int T_OVP_BLANK     = 115
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic in_above_uvlo,
  input  logic in_above_bat,
  input  logic in_above_ovp,
  input  logic chg_enabled,
  output logic pg_sink,
  output logic ovp_shutdown,
  output logic aux_reg_en
);

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_DG = imax(imax(imax(T_UVLO_EXIT, T_OVP_ENTER_EN), imax(T_OVP_EXIT_EN, T_OVP_EXIT_DIS)),
                               imax(T_SLEEP_ENTER_EN, T_SLEEP_EXIT));
  localparam int CW  = $clog2(MAX_DG + 2);
  localparam int BW  = $clog2(T_OVP_BLANK + 2);

  typedef enum logic [1:0] {C_UVLO, C_OVP, C_SLEEP} cause_e;

  logic          raw_good;
  cause_e        blk_cause, cause_q;
  logic [CW-1:0] limit, dg_cnt;
  logic          pg_q;
  logic [BW-1:0] blank_cnt;
  logic          trip_q;

  assign raw_good = in_above_uvlo & in_above_bat & ~in_above_ovp;

  always_comb begin
    if (!in_above_uvlo)     blk_cause = C_UVLO;
    else if (in_above_ovp)  blk_cause = C_OVP;
    else                    blk_cause = C_SLEEP;
  end

  always_comb begin
    if (pg_q) begin
      unique case (blk_cause)
        C_OVP:   limit = chg_enabled ? CW'(T_OVP_ENTER_EN) : '0;
        C_SLEEP: limit = chg_enabled ? CW'(T_SLEEP_ENTER_EN) : '0;
        default: limit = '0;
      endcase
    end else begin
      unique case (cause_q)
        C_OVP:   limit = chg_enabled ? CW'(T_OVP_EXIT_EN) : CW'(T_OVP_EXIT_DIS);
        C_SLEEP: limit = CW'(T_SLEEP_EXIT);
        default: limit = CW'(T_UVLO_EXIT);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q    <= 1'b0;
      cause_q <= C_UVLO;
      dg_cnt  <= '0;
    end else begin
      if (!raw_good) cause_q <= blk_cause;
      if (raw_good == pg_q) begin
        dg_cnt <= '0;
      end else if (dg_cnt >= limit) begin
        pg_q   <= raw_good;
        dg_cnt <= '0;
      end else if (tick_us) begin
        dg_cnt <= dg_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_cnt <= '0;
      trip_q    <= 1'b0;
    end else if (!(in_above_ovp && in_above_uvlo)) begin
      blank_cnt <= '0;
      trip_q    <= 1'b0;
    end else if (!trip_q) begin
      if (blank_cnt >= BW'(T_OVP_BLANK)) trip_q <= 1'b1;
      else if (tick_us)                  blank_cnt <= blank_cnt + 1'b1;
    end
  end

  assign pg_sink      = pg_q;
  assign ovp_shutdown = trip_q;
  assign aux_reg_en   = in_above_uvlo & ~trip_q;

  // R2
  uvlo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_above_uvlo |=> !pg_sink);

  // R4
  ovp_dis_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_sink && in_above_uvlo && in_above_ovp && !chg_enabled) |=> !pg_sink);

  // R8
  ovp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_above_ovp |=> !ovp_shutdown);

  // R8
  ovp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovp_shutdown) |-> ($past(in_above_ovp) && $past(in_above_uvlo)));

  // R10
  pg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pg_sink) |-> ($past(raw_good) == pg_sink));

endmodule

// File: tb/pwr_good_qual_tb.sv
module pwr_good_qual_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b1;
  logic uvlo = 1'b1, bat = 1'b1, ovp = 1'b0, en = 1'b1;
  logic pg_sink, ovp_shutdown, aux_reg_en;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  int    q_cyc[$];
  int    q_sig[$];
  bit    q_val[$];
  string q_tag[$];

  localparam int SIG_PG = 0, SIG_SHUT = 1, SIG_AUX = 2;

  always #10 clk = ~clk;

  pwr_good_qual dut_i (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
    .in_above_uvlo(uvlo), .in_above_bat(bat), .in_above_ovp(ovp),
    .chg_enabled(en),
    .pg_sink(pg_sink), .ovp_shutdown(ovp_shutdown), .aux_reg_en(aux_reg_en)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit got, input bit exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", tag, cyc, got, exp);
    end
  endtask

  function automatic bit sample(input int s);
    if (s == SIG_PG)   return pg_sink;
    if (s == SIG_SHUT) return ovp_shutdown;
    return aux_reg_en;
  endfunction

  always @(negedge clk) begin
    for (int i = q_cyc.size() - 1; i >= 0; i--) begin
      if (q_cyc[i] == cyc) begin
        chk(sample(q_sig[i]), q_val[i], q_tag[i]);
        q_cyc.delete(i); q_sig.delete(i); q_val.delete(i); q_tag.delete(i);
      end
    end
  end

  task automatic expect_at(input int d, input int s, input bit v, input string tag);
    q_cyc.push_back(cyc + d); q_sig.push_back(s); q_val.push_back(v); q_tag.push_back(tag);
  endtask

  task automatic expect_edge(input int s, input int n, input bit oldv, input bit newv, input string tag);
    if (n > 0) expect_at(n, s, oldv, tag);
    expect_at(n + 1, s, newv, tag);
  endtask

  task automatic drive(input bit u, input bit b, input bit o, input bit e);
    @(posedge clk); #5;
    uvlo = u; bat = b; ovp = o; en = e;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #5;
    chk(pg_sink, 1'b0, "R1 pg in reset");
    chk(ovp_shutdown, 1'b0, "R1 shutdown in reset");
    rst_n = 1'b1;
    expect_edge(SIG_PG, 230, 1'b0, 1'b1, "R3 rise after reset");
    idle(240);

    drive(1, 1, 1, 1);
    expect_edge(SIG_PG, 100, 1'b1, 1'b0, "R4 ovp enter enabled");
    expect_edge(SIG_SHUT, 115, 1'b0, 1'b1, "R8 shutdown blanking");
    expect_edge(SIG_AUX, 115, 1'b1, 1'b0, "R9 aux off on shutdown");
    idle(130);
    drive(1, 1, 0, 1);
    expect_at(1, SIG_SHUT, 1'b0, "R8 shutdown release");
    expect_at(1, SIG_AUX, 1'b1, "R9 aux back on");
    expect_edge(SIG_PG, 450, 1'b0, 1'b1, "R5 ovp leave enabled");
    idle(460);

    drive(1, 1, 1, 0);
    expect_at(1, SIG_PG, 1'b0, "R4 ovp enter disabled");
    expect_at(1, SIG_AUX, 1'b1, "R9 aux ignores enable");
    idle(20);
    drive(1, 1, 0, 0);
    expect_at(1, SIG_SHUT, 1'b0, "R8 no trip before blanking");
    expect_edge(SIG_PG, 500, 1'b0, 1'b1, "R5 ovp leave disabled");
    idle(510);

    drive(1, 0, 0, 1);
    expect_edge(SIG_PG, 32000, 1'b1, 1'b0, "R6 sleep enter enabled");
    idle(32010);
    drive(1, 1, 0, 1);
    expect_edge(SIG_PG, 500, 1'b0, 1'b1, "R7 sleep leave enabled");
    idle(510);

    drive(1, 0, 0, 0);
    expect_at(1, SIG_PG, 1'b0, "R6 sleep enter disabled");
    idle(5);
    drive(1, 1, 0, 1);
    expect_edge(SIG_PG, 500, 1'b0, 1'b1, "R7 sleep leave");
    idle(510);

    drive(0, 1, 0, 1);
    expect_at(1, SIG_PG, 1'b0, "R2 uvlo immediate");
    expect_at(1, SIG_AUX, 1'b0, "R9 aux off in uvlo");
    idle(5);
    drive(1, 1, 0, 1);
    expect_edge(SIG_PG, 230, 1'b0, 1'b1, "R3 uvlo leave");
    idle(240);

    drive(1, 1, 1, 1);
    idle(50);
    drive(1, 1, 0, 1);
    expect_at(1, SIG_PG, 1'b1, "R10 revert keeps pg");
    expect_at(60, SIG_PG, 1'b1, "R10 revert keeps pg");
    idle(60);
    drive(1, 1, 1, 1);
    expect_edge(SIG_PG, 100, 1'b1, 1'b0, "R10 full restart");
    expect_at(100, SIG_SHUT, 1'b0, "R10 blanking restart");
    idle(105);
    drive(1, 1, 0, 1);
    expect_at(1, SIG_SHUT, 1'b0, "R8 no trip after revert");
    expect_edge(SIG_PG, 450, 1'b0, 1'b1, "R10 rise after ovp");
    idle(460);

    drive(0, 1, 1, 1);
    expect_at(1, SIG_PG, 1'b0, "R11 uvlo over ovp falling");
    idle(10);
    drive(1, 1, 0, 1);
    expect_edge(SIG_PG, 230, 1'b0, 1'b1, "R11 uvlo over ovp rising");
    idle(240);

    drive(1, 0, 1, 1);
    expect_edge(SIG_PG, 100, 1'b1, 1'b0, "R11 ovp over sleep falling");
    idle(100);
    drive(1, 1, 0, 1);
    expect_at(1, SIG_SHUT, 1'b0, "R11 no trip");
    expect_edge(SIG_PG, 450, 1'b0, 1'b1, "R11 ovp over sleep rising");
    idle(460);

    while (q_cyc.size() > 0) @(posedge clk);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule